// File: doc/BRIEF.md
# Burst Frame Sequencer

This block is the timing core of a time-division duplex controller. A four-state machine decides when timing may run. It sits idle until it is enabled. It then waits armed for a sync event. After the sync it counts out a programmable startup delay. It then plays frames of a programmed length. A shared reference counter counts the delay cycles and then the cycles within each frame. A second counter tracks how many frames of the burst have been played.

A burst count of zero means frames repeat for as long as enable stays high. A nonzero burst count plays exactly that many frames. The machine then drops back to the armed state to wait for the next sync. When the sync-reset option is set, a sync event during the delay or during a frame restarts the reference counter at zero. Downstream channel comparators use the counter value and the running flag. The end-of-frame strobe marks each frame boundary. All pins are plain control and status levels: there is no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `tdd_frame_sequencer`

## Requirements
- R1: While the synchronous active-low reset is held, and on the first cycle after it, state is 0 (idle), the counter is 0, and both the frame strobe and the running flag are low.
- R2: The state output uses the encoding idle=0, armed=1, waiting=2, running=3. From idle, a high enable moves the state to armed on the next clock. Armed is held with the counter at 0 for as long as no sync event arrives.
- R3: A sync event in armed with a nonzero startup delay D gives the waiting state for exactly D cycles, with the counter showing 0 to D-1. Running then begins with the counter at 0. With D equal to 0, running begins on the clock right after the sync.
- R4: In running, the counter steps by one each cycle from 0 to L-1, where L is the frame length. The frame strobe is high on exactly the cycle where the counter shows L-1, and the counter then returns to 0. A frame length of 0 or 1 gives one-cycle frames, with the strobe high on every running cycle.
- R5: With a nonzero burst count N, the clock after the N-th frame strobe gives state armed with the counter at 0. A new sync event then starts a new delay and burst.
- R6: With a burst count of 0, frames keep repeating while enable stays high.
- R7: With sync-reset set, a sync event in waiting or in running sets the counter to 0 on the next clock, and the state does not change. In waiting, the full startup delay then restarts.
- R8: With sync-reset clear, a sync event in waiting or in running has no effect, and the counter keeps incrementing.
- R9: A low enable moves the machine to idle with the counter at 0 on the next clock, from any state.
- R10: The running flag is high exactly when the state is running.

Reset is a synchronous, active-low input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Allows the machine to leave idle; low forces idle |
| sync_event | input | 1 | Combined sync pulse from all sources |
| sync_reset_en | input | 1 | When high, a sync during the delay or a frame clears the counter |
| startup_delay | input | CNT_W | Delay, in cycles, between the sync and the first frame |
| frame_length | input | CNT_W | Frame length in cycles |
| burst_count | input | BURST_W | Frames per burst; 0 means no limit |
| ref_count | output | CNT_W | Reference counter value |
| state | output | 2 | Current machine state |
| frame_end | output | 1 | One-cycle strobe on the last cycle of each frame |
| running | output | 1 | High while frames are playing |

## Verification
A state register stuck or advanced early shows on the state port on the very next clock. A slip in the waiting-to-running transfer also offsets every later counter value and every frame strobe by the same number of cycles. A fault in the frame counter shows only at the end of a burst. The return to armed then comes one frame too early or too late, so the check traces complete bursts cycle by cycle for several delay, length and count combinations. Sync-reset faults appear as a counter value that fails to return to 0, or that returns to 0 when the option is clear, one clock after the pulse.

// File: rtl/tdd_seq_pkg.sv
package tdd_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARMED   = 2'd1,
    ST_WAITING = 2'd2,
    ST_RUNNING = 2'd3
  } seq_state_t;
endpackage

// File: rtl/tdd_seq_fsm.sv
module tdd_seq_fsm
  import tdd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       sync_event,
  input  logic       sync_reset_en,
  input  logic       delay_zero,
  input  logic       delay_last,
  input  logic       frame_last,
  input  logic       burst_last,
  output seq_state_t state
);
  seq_state_t state_nx;

  always_comb begin
    state_nx = state;
    if (!enable) begin
      state_nx = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:    state_nx = ST_ARMED;
        ST_ARMED:   if (sync_event) state_nx = delay_zero ? ST_RUNNING : ST_WAITING;
        ST_WAITING: if (!(sync_event && sync_reset_en) && delay_last) state_nx = ST_RUNNING;
        ST_RUNNING: if (frame_last && burst_last) state_nx = ST_ARMED;
        default:    state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  // R9: disable always lands in idle
  a_r9_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> state == ST_IDLE);
  // R2: idle only leaves toward armed
  a_r2_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |=> (state == ST_IDLE || state == ST_ARMED));
  // R3: no timing starts from armed without a sync
  a_r3_armed_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED && !sync_event) |=> (state == ST_ARMED || state == ST_IDLE));
endmodule

// File: rtl/tdd_seq_refcnt.sv
module tdd_seq_refcnt
  import tdd_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  seq_state_t       state,
  input  logic             sync_event,
  input  logic             sync_reset_en,
  input  logic [CNT_W-1:0] startup_delay,
  input  logic [CNT_W-1:0] frame_length,
  output logic [CNT_W-1:0] count,
  output logic             delay_last,
  output logic             frame_last
);
  logic [CNT_W:0] count_inc;
  logic           sync_clear;

  assign count_inc  = {1'b0, count} + 1'b1;
  assign delay_last = count_inc >= {1'b0, startup_delay};
  assign frame_last = count_inc >= {1'b0, frame_length};
  assign sync_clear = sync_event && sync_reset_en;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      count <= '0;
    end else begin
      case (state)
        ST_WAITING: count <= (sync_clear || delay_last) ? '0 : count_inc[CNT_W-1:0];
        ST_RUNNING: count <= (sync_clear || frame_last) ? '0 : count_inc[CNT_W-1:0];
        default:    count <= '0;
      endcase
    end
  end

  // R4: the cycle after a frame boundary the counter is back at zero
  a_r4_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUNNING && frame_last) |=> count == '0);
  // R7: sync-reset clears the counter during delay or frames
  a_r7_sync_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_WAITING || state == ST_RUNNING) && sync_event && sync_reset_en) |=> count == '0);
  // R8: without sync-reset, a running counter not at a boundary keeps stepping
  a_r8_sync_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state == ST_RUNNING && !sync_reset_en && !frame_last) |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/tdd_seq_burstcnt.sv
module tdd_seq_burstcnt
  import tdd_seq_pkg::*;
#(
  parameter int BURST_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  seq_state_t         state,
  input  logic               frame_last,
  input  logic [BURST_W-1:0] burst_count,
  output logic               burst_last
);
  logic [BURST_W-1:0] frames;
  logic [BURST_W:0]   frames_inc;

  assign frames_inc = {1'b0, frames} + 1'b1;
  assign burst_last = (burst_count != '0) && (frames_inc >= {1'b0, burst_count});

  always_ff @(posedge clk) begin
    if (!rst_n || !enable || state != ST_RUNNING) begin
      frames <= '0;
    end else if (frame_last) begin
      frames <= burst_last ? '0 : frames_inc[BURST_W-1:0];
    end
  end

  // R6: an unlimited burst never reports completion
  a_r6_no_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_count == '0) |-> !burst_last);
  // R5: completion restarts the frame tally
  a_r5_burst_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state == ST_RUNNING && frame_last && burst_last) |=> frames == '0);
endmodule

// File: rtl/tdd_frame_sequencer.sv
module tdd_frame_sequencer
  import tdd_seq_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int BURST_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               sync_event,
  input  logic               sync_reset_en,
  input  logic [CNT_W-1:0]   startup_delay,
  input  logic [CNT_W-1:0]   frame_length,
  input  logic [BURST_W-1:0] burst_count,
  output logic [CNT_W-1:0]   ref_count,
  output logic [1:0]         state,
  output logic               frame_end,
  output logic               running
);
  seq_state_t st;
  logic delay_last, frame_last, burst_last, delay_zero;

  assign delay_zero = (startup_delay == '0);

  tdd_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sync_event(sync_event),
    .sync_reset_en(sync_reset_en), .delay_zero(delay_zero), .delay_last(delay_last),
    .frame_last(frame_last), .burst_last(burst_last), .state(st)
  );

  tdd_seq_refcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(enable), .state(st), .sync_event(sync_event),
    .sync_reset_en(sync_reset_en), .startup_delay(startup_delay),
    .frame_length(frame_length), .count(ref_count), .delay_last(delay_last),
    .frame_last(frame_last)
  );

  tdd_seq_burstcnt #(.BURST_W(BURST_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .enable(enable), .state(st), .frame_last(frame_last),
    .burst_count(burst_count), .burst_last(burst_last)
  );

  assign state     = st;
  assign running   = (st == ST_RUNNING);
  assign frame_end = running && frame_last;

  // R10: running flag and state code agree
  a_r10_running_flag: assert property (@(posedge clk) disable iff (!rst_n)
    running == (state == 2'd3));
  // R4: strobe only while running
  a_r4_strobe_running: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> running);
endmodule

// File: tb/sim_tdd_frame_sequencer.sv
module sim_tdd_frame_sequencer;
  localparam int CW = 16;
  localparam int BW = 16;

  logic clk = 1'b0;
  logic rst_n, enable, sync_event, sync_reset_en;
  logic [CW-1:0] startup_delay, frame_length;
  logic [BW-1:0] burst_count;
  logic [CW-1:0] ref_count;
  logic [1:0] state;
  logic frame_end, running;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tdd_frame_sequencer #(.CNT_W(CW), .BURST_W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sync_event(sync_event),
    .sync_reset_en(sync_reset_en), .startup_delay(startup_delay),
    .frame_length(frame_length), .burst_count(burst_count), .ref_count(ref_count),
    .state(state), .frame_end(frame_end), .running(running)
  );

  // vector: delay, frame length, burst count
  localparam int NV = 6;
  localparam int VEC [NV][3] = '{
    '{3, 4, 2}, '{0, 5, 1}, '{2, 1, 3}, '{1, 3, 0}, '{0, 0, 2}, '{5, 2, 4}
  };

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string tag, input int st, input int cnt, input bit fe, input bit rn);
    checks++;
    if (state !== st[1:0] || ref_count !== cnt[CW-1:0] || frame_end !== fe || running !== rn) begin
      errors++;
      $display("FAIL %s: state=%0d cnt=%0d fe=%0b run=%0b expected state=%0d cnt=%0d fe=%0b run=%0b",
               tag, state, ref_count, frame_end, running, st, cnt, fe, rn);
    end
  endtask

  task automatic pulse_sync();
    sync_event = 1'b1;
    step();
    sync_event = 1'b0;
  endtask

  task automatic setup(input int d, input int l, input int b);
    enable = 1'b0;
    startup_delay = d[CW-1:0];
    frame_length = l[CW-1:0];
    burst_count = b[BW-1:0];
    step();
    enable = 1'b1;
    step();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; sync_event = 1'b0; sync_reset_en = 1'b0;
    startup_delay = '0; frame_length = 16'd4; burst_count = '0;
    step(3);
    chk("R1 in reset", 0, 0, 0, 0);
    rst_n = 1'b1;
    step();
    chk("R1 after reset", 0, 0, 0, 0);

    // table walk: R3 R4 R5 R6 R10
    for (int v = 0; v < NV; v++) begin
      int d, l, b, le, total;
      d = VEC[v][0]; l = VEC[v][1]; b = VEC[v][2];
      le = (l < 1) ? 1 : l;
      setup(d, l, b);
      chk("R2 armed", 1, 0, 0, 0);
      pulse_sync();
      total = d + le * ((b == 0) ? 4 : b) + 3;
      for (int t = 0; t < total; t++) begin
        int est, ecnt, r, idx;
        bit efe;
        string tag;
        if (d > 0 && t < d) begin
          est = 2; ecnt = t; efe = 0; tag = "R3 delay";
        end else begin
          r = t - d; idx = r / le;
          if (b != 0 && idx >= b) begin
            est = 1; ecnt = 0; efe = 0; tag = "R5 burst done";
          end else begin
            est = 3; ecnt = r % le; efe = (ecnt == le - 1);
            tag = (b == 0) ? "R6 repeat" : "R4 frame";
          end
        end
        chk(tag, est, ecnt, efe, est == 3);
        step();
      end
    end

    // R2: armed holds without sync
    setup(0, 6, 0);
    step(5);
    chk("R2 armed hold", 1, 0, 0, 0);

    // R5: resync after burst
    setup(0, 2, 1);
    pulse_sync();
    chk("R5 first frame", 3, 0, 0, 1);
    step();
    chk("R5 last cycle", 3, 1, 1, 1);
    step();
    chk("R5 back armed", 1, 0, 0, 0);
    pulse_sync();
    chk("R5 resync", 3, 0, 0, 1);

    // R7: sync reset in running
    sync_reset_en = 1'b1;
    setup(0, 10, 0);
    pulse_sync();
    step(4);
    chk("R7 pre", 3, 4, 0, 1);
    pulse_sync();
    chk("R7 running clear", 3, 0, 0, 1);
    step();
    chk("R7 running resume", 3, 1, 0, 1);

    // R7: sync reset in waiting restarts the delay
    setup(8, 10, 0);
    pulse_sync();
    step(3);
    chk("R7 wait pre", 2, 3, 0, 0);
    pulse_sync();
    chk("R7 wait clear", 2, 0, 0, 0);
    step(7);
    chk("R7 wait end", 2, 7, 0, 0);
    step();
    chk("R7 wait to run", 3, 0, 0, 1);

    // R8: sync ignored without sync reset
    sync_reset_en = 1'b0;
    setup(0, 10, 0);
    pulse_sync();
    step(4);
    pulse_sync();
    chk("R8 running ignored", 3, 5, 0, 1);
    setup(6, 10, 0);
    pulse_sync();
    step(2);
    pulse_sync();
    chk("R8 waiting ignored", 2, 3, 0, 0);

    // R9: disable from waiting, running, armed
    enable = 1'b0;
    step();
    chk("R9 from waiting", 0, 0, 0, 0);
    setup(0, 10, 0);
    pulse_sync();
    step(3);
    enable = 1'b0;
    step();
    chk("R9 from running", 0, 0, 0, 0);
    setup(0, 10, 0);
    enable = 1'b0;
    step();
    chk("R9 from armed", 0, 0, 0, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule